// File: doc/BRIEF.md
# Channel Volume and Mute Stage

This block scales six two's-complement audio streams, grouped as three left/right pairs, by a per-channel 8-bit gain code and silences them when asked. Code 80h is unity gain. Gain is linear, and the full product is cut back to the sample width. Codes above unity are treated as unity, so no setting can amplify.

Silencing comes from two sources. Three pair-mute controls each silence one stereo pair. An automatic mute counts consecutive all-zero samples per channel against a programmable run length. The run length is chosen to span about 0.2 s at the current frame rate, for example 8820 frames at 44.1 kHz. Both sources are sampled only on the frame tick, so a channel's mute state changes only at a frame boundary. A muted channel emits exactly zero.

Each valid sample yields one registered output sample a cycle later.

Top module: `chan_vol_mute`

## Requirements
- R1: While reset is active and after it is released, out_valid is all zero and out_data is all zero until the first valid sample.
- R2: With a gain code of exactly 80h on an unmuted channel, the output sample equals the input sample.
- R3: For a gain code c of 80h or less on an unmuted channel, the output is floor(sample × c / 128) as a signed value, truncated to the sample width.
- R4: Any gain code above 80h produces the same output as code 80h.
- R5: Each of the six channels uses only its own gain code. Channel n takes bits [8n+7:8n] of vol_code, and channel n's sample occupies bits [24n+23:24n] of in_data and out_data.
- R6: Bit k of pair_mute set to 1 makes channels 2k and 2k+1 output exactly zero. Channel numbers run 0 to 5, and 0/1 form the first left/right pair. The mute takes effect from the first frame tick after the bit is set.
- R7: A change of pair_mute or of the automatic mute condition between frame ticks does not alter any channel's mute state until the next frame tick.
- R8: With amute_dis at 0, a channel whose count of consecutive zero samples has reached zero_limit at a frame tick is muted from that tick on, so a following nonzero sample outputs zero.
- R9: A nonzero sample clears the channel's zero-run count. The automatic mute is then released at the next frame tick.
- R10: With amute_dis at 1, a long zero run never mutes a channel.
- R11: out_valid bit n is high exactly one cycle after in_valid bit n was high, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse per frame, derived from the word clock |
| in_valid | input | 6 | Per-channel sample strobe |
| in_data | input | 144 | Six packed 24-bit signed samples |
| vol_code | input | 48 | Six packed 8-bit gain codes |
| pair_mute | input | 3 | Per-pair mute, 1 = silence the pair |
| amute_dis | input | 1 | 0 = automatic mute active, 1 = disabled |
| zero_limit | input | 16 | Zero-run length, in samples, that triggers the automatic mute |
| out_valid | output | 6 | Per-channel output strobe |
| out_data | output | 144 | Six packed 24-bit scaled samples |

## Verification
The hardest case to reach from the ports is a channel that is automatically muted while its input is already nonzero again. Only in that window does the automatic mute differ visibly from plain zero-in, zero-out. The stimulus feeds one channel a run of zero samples that reaches the limit, issues a frame tick, and then sends a nonzero sample before the next tick. That sample must come out as zero, and after the following tick the scaled value must return. The same run is repeated with the automatic mute disabled. The gain path is swept across all 256 codes on every channel, using samples that include both extreme values and minus one.

// File: rtl/cvm_pkg.sv
package cvm_pkg;
   // channels per stereo pair
   localparam int PAIR = 2;

   function automatic int pair_of(input int ch);
      return ch / PAIR;
   endfunction
endpackage

// File: rtl/cvm_scaler.sv
module cvm_scaler #(
   parameter int DW = 24,
   parameter int VW = 8
) (
   input  logic [DW-1:0] sample,
   input  logic [VW-1:0] code,
   output logic [DW-1:0] scaled
);
   localparam int SHIFT = VW - 1;
   localparam logic [VW-1:0] UNITY = VW'(1) << SHIFT;

   logic [VW-1:0]        code_c;
   logic signed [DW+VW:0] prod;

   // codes above unity are held at unity
   assign code_c = (code > UNITY) ? UNITY : code;
   assign prod   = $signed(sample) * $signed({1'b0, code_c});
   assign scaled = DW'(prod >>> SHIFT);
endmodule

// File: rtl/cvm_zero_run.sv
module cvm_zero_run #(
   parameter int ZW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  logic          is_zero,
   input  logic [ZW-1:0] limit,
   output logic          reached
);
   logic [ZW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (valid) begin
         if (!is_zero)        run_q <= '0;
         else if (run_q != '1) run_q <= run_q + 1'b1;
      end
   end

   assign reached = (run_q >= limit);
endmodule

// File: rtl/chan_vol_mute.sv
module chan_vol_mute #(
   parameter int NCH          = 6,
   parameter int DW           = 24,
   parameter int VW           = 8,
   parameter int ZW           = 16,
   parameter bit HAS_AUTOMUTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_tick,
   input  logic [NCH-1:0]    in_valid,
   input  logic [NCH*DW-1:0] in_data,
   input  logic [NCH*VW-1:0] vol_code,
   input  logic [NCH/2-1:0]  pair_mute,
   input  logic              amute_dis,
   input  logic [ZW-1:0]     zero_limit,
   output logic [NCH-1:0]    out_valid,
   output logic [NCH*DW-1:0] out_data
);
   import cvm_pkg::*;

   localparam int NPAIR = NCH / PAIR;

   if (NCH % PAIR != 0) begin : g_bad_nch
      $error("NCH must be a whole number of stereo pairs");
   end
   if (VW < 2 || DW < VW) begin : g_bad_width
      $error("VW must be at least 2 and not wider than DW");
   end
   if (ZW < 1) begin : g_bad_zw
      $error("ZW must be at least 1");
   end

   logic [NCH-1:0] mute_q;
   logic [NCH-1:0] auto_hit;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [DW-1:0] samp;
      logic [DW-1:0] scaled;
      assign samp = in_data[i*DW +: DW];

      cvm_scaler #(.DW(DW), .VW(VW)) u_scale (
         .sample (samp),
         .code   (vol_code[i*VW +: VW]),
         .scaled (scaled)
      );

      if (HAS_AUTOMUTE) begin : g_auto
         logic reached;
         cvm_zero_run #(.ZW(ZW)) u_zrun (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid   (in_valid[i]),
            .is_zero (samp == '0),
            .limit   (zero_limit),
            .reached (reached)
         );
         assign auto_hit[i] = reached & ~amute_dis;
      end else begin : g_noauto
         assign auto_hit[i] = 1'b0;
      end

      // mute state moves only on the frame tick
      always_ff @(posedge clk) begin
         if (!rst_n)          mute_q[i] <= 1'b0;
         else if (frame_tick) mute_q[i] <= pair_mute[pair_of(i)] | auto_hit[i];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid[i]          <= 1'b0;
            out_data[i*DW +: DW]  <= '0;
         end else begin
            out_valid[i] <= in_valid[i];
            if (in_valid[i])
               out_data[i*DW +: DW] <= mute_q[i] ? '0 : scaled;
         end
      end
   end

   if (NPAIR < 1) begin : g_bad_pairs
      $error("at least one stereo pair required");
   end
endmodule

// File: rtl/chan_vol_mute_chk.sv
module chan_vol_mute_chk #(
   parameter int NCH = 6,
   parameter int DW  = 24,
   parameter int VW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_tick,
   input logic [NCH-1:0]    in_valid,
   input logic [NCH*DW-1:0] in_data,
   input logic [NCH*VW-1:0] vol_code,
   input logic [NCH-1:0]    out_valid,
   input logic [NCH*DW-1:0] out_data,
   input logic [NCH-1:0]    mute_q
);
   localparam logic [VW-1:0] UNITY = VW'(1) << (VW - 1);

   for (genvar i = 0; i < NCH; i++) begin : g_c
      // R2 R4
      unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid[i] && !mute_q[i] && vol_code[i*VW +: VW] >= UNITY)
         |=> out_data[i*DW +: DW] == $past(in_data[i*DW +: DW]));

      // R6
      muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid[i] && mute_q[i]) |=> out_data[i*DW +: DW] == '0);

      // R7
      mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !frame_tick |=> $stable(mute_q[i]));

      // R11
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[i] |-> $past(in_valid[i]));

      // R3
      zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid[i] && in_data[i*DW +: DW] == '0) |=> out_data[i*DW +: DW] == '0);
   end
endmodule

bind chan_vol_mute chan_vol_mute_chk #(.NCH(NCH), .DW(DW), .VW(VW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_tick (frame_tick),
   .in_valid   (in_valid),
   .in_data    (in_data),
   .vol_code   (vol_code),
   .out_valid  (out_valid),
   .out_data   (out_data),
   .mute_q     (mute_q)
);

// File: tb/tb_chan_vol_mute.sv
module tb_chan_vol_mute;
   localparam int NCH = 6;
   localparam int DW  = 24;
   localparam int VW  = 8;
   localparam int ZW  = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              frame_tick;
   logic [NCH-1:0]    in_valid;
   logic [NCH*DW-1:0] in_data;
   logic [NCH*VW-1:0] vol_code;
   logic [NCH/2-1:0]  pair_mute;
   logic              amute_dis;
   logic [ZW-1:0]     zero_limit;
   logic [NCH-1:0]    out_valid;
   logic [NCH*DW-1:0] out_data;

   always #10 clk = ~clk;

   chan_vol_mute #(.NCH(NCH), .DW(DW), .VW(VW), .ZW(ZW)) dut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .in_valid(in_valid), .in_data(in_data), .vol_code(vol_code),
      .pair_mute(pair_mute), .amute_dis(amute_dis), .zero_limit(zero_limit),
      .out_valid(out_valid), .out_data(out_data)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [DW-1:0] smp [NCH];
   int            zc  [NCH];
   bit            mref[NCH];

   function automatic logic [DW-1:0] model(input logic [DW-1:0] s, input logic [VW-1:0] c);
      longint sv, p;
      int cc;
      cc = (c > 8'h80) ? 128 : int'(c);
      sv = longint'($signed(s));
      p  = (sv * cc) >>> 7;
      return p[DW-1:0];
   endfunction

   task automatic check(input string tag, input int ch, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s ch%0d act=%h exp=%h", tag, ch, act, exp);
      end
   endtask

   task automatic do_tick();
      @(negedge clk);
      frame_tick = 1'b1;
      for (int i = 0; i < NCH; i++)
         mref[i] = pair_mute[i/2] | (!amute_dis && zc[i] >= int'(zero_limit));
      @(negedge clk);
      frame_tick = 1'b0;
      // R11: no strobe without a preceding sample
      check("R11", 0, 32'(out_valid), 32'd0);
   endtask

   task automatic send(input logic [NCH-1:0] mask, input string tag);
      @(negedge clk);
      in_valid = mask;
      for (int i = 0; i < NCH; i++) in_data[i*DW +: DW] = smp[i];
      @(negedge clk);
      check("R11", 0, 32'(out_valid), 32'(mask));
      for (int i = 0; i < NCH; i++) begin
         if (mask[i]) begin
            logic [VW-1:0] c;
            logic [DW-1:0] e;
            string t;
            c = vol_code[i*VW +: VW];
            e = mref[i] ? '0 : model(smp[i], c);
            t = (tag != "") ? tag : ((c > 8'h80) ? "R4" : "R3");
            check(t, i, 32'(out_data[i*DW +: DW]), 32'(e));
            if (smp[i] == '0) begin
               if (zc[i] < 65535) zc[i]++;
            end else zc[i] = 0;
         end
      end
      in_valid = '0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; frame_tick = 1'b0; in_valid = '0; in_data = '0;
      vol_code = {NCH{8'h80}}; pair_mute = '0; amute_dis = 1'b0; zero_limit = 16'd4;
      for (int i = 0; i < NCH; i++) begin zc[i] = 0; mref[i] = 1'b0; smp[i] = '0; end
      repeat (3) @(negedge clk);
      check("R1", 0, 32'(out_valid), 32'd0);
      check("R1", 0, out_data[31:0], 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 0, 32'(out_valid), 32'd0);
      check("R1", 1, 32'(out_data[DW +: DW]), 32'd0);

      // R2: unity on extremes
      smp[0] = 24'h7FFFFF; smp[1] = 24'h800000; smp[2] = 24'hFFFFFF;
      smp[3] = 24'h000001; smp[4] = 24'h123456; smp[5] = 24'hABCDEF;
      do_tick();
      send('1, "R2");

      // R3 R4 R5: every code on every channel
      for (int k = 0; k < 256; k++) begin
         for (int i = 0; i < NCH; i++) begin
            vol_code[i*VW +: VW] = 8'((k + i*37) % 256);
            case ((k + i) % 5)
               0: smp[i] = 24'h7FFFFF;
               1: smp[i] = 24'h800000;
               2: smp[i] = 24'hFFFFFF;
               default: smp[i] = 24'((k*7919 + i*104729 + 1) % 16777216);
            endcase
         end
         do_tick();
         send('1, "");
      end

      // R5: same sample, distinct codes
      for (int i = 0; i < NCH; i++) begin
         smp[i] = 24'h400000;
         vol_code[i*VW +: VW] = 8'(8'h10 * (i + 1));
      end
      do_tick();
      send('1, "R5");

      // R6 R7: pair mutes
      for (int i = 0; i < NCH; i++) begin
         vol_code[i*VW +: VW] = 8'h80;
         smp[i] = 24'(24'h010203 * (i + 1));
      end
      pair_mute = 3'b101;
      do_tick();
      send('1, "R6");
      pair_mute = 3'b010;
      send('1, "R7");
      do_tick();
      send('1, "R6");
      pair_mute = 3'b000;
      do_tick();
      send('1, "R6");

      // R11: partial strobes
      send(6'b010101, "R11");
      send(6'b101010, "R11");

      // R8: zero run on channel 0 reaches limit
      smp[0] = '0;
      for (int f = 0; f < 5; f++) begin
         do_tick();
         send('1, "R8");
      end
      do_tick();
      smp[0] = 24'h123456;
      send('1, "R8");
      // R9: released on the next tick
      do_tick();
      send('1, "R9");
      // exactly limit-1 zeros does not mute
      smp[0] = '0;
      for (int f = 0; f < 3; f++) begin
         do_tick();
         send('1, "R8");
      end
      do_tick();
      smp[0] = 24'h654321;
      send('1, "R8");

      // R10: disabled automatic mute
      amute_dis = 1'b1;
      smp[0] = '0;
      for (int f = 0; f < 6; f++) begin
         do_tick();
         send('1, "R10");
      end
      do_tick();
      smp[0] = 24'h0FEDCB;
      send('1, "R10");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule